// File: doc/BRIEF.md
# Asynchronous SRAM Controller

This block converts single-beat read and write requests, presented on an on-chip valid/ready port, into bus cycles on an external asynchronous static RAM of 32K bytes. The RAM has three active-low strobes: chip select, output enable and write enable. The controller owns a 15-bit address and a byte-wide data path. That data path is split into an outgoing value, an incoming value and a drive enable, so that the pad can form the bidirectional bus.

Every interval on the bus is a parameter counted in system clocks. Each one is rounded up from the nanosecond limits of the RAM:

- the read access window,
- the time the RAM needs to release the bus,
- the data setup ahead of the write end,
- a floor on the write strobe width.

Writes are controlled by the write strobe. Output enable is already high when the write strobe falls. The controller turns on its own drivers only after the release time has passed. It keeps the data on the bus for one cycle after the write strobe rises.

A read keeps chip select and output enable low for the access window. The bus value is captured on the last cycle of that window. The byte is returned with a one-cycle response pulse. The request port accepts a new request only while no bus cycle is in progress.

Top module: `sram_ctrl`

## Requirements
- R1: While rst_ni is low, all three strobes are high, mem_dq_oe_o is low, rsp_valid_o is low and req_ready_o is high.
- R2: An accepted read (req_we_i = 0) holds chip select and output enable low, with write enable high, for exactly RD_CYC consecutive cycles, starting on the cycle after acceptance.
- R3: The read byte is the value on mem_dq_i in the last cycle of the read window. It appears on rsp_rdata_o, with rsp_valid_o high for exactly one cycle, in the first cycle after the strobes rise. rsp_valid_o is low in every other cycle.
- R4: An accepted write (req_we_i = 1) holds chip select and write enable low for WE_CYC = max(TURN_CYC + SETUP_CYC, WE_MIN_CYC) consecutive cycles. Output enable stays high throughout the write.
- R5: During a write, mem_dq_oe_o first rises after write enable has been low for TURN_CYC full cycles. mem_dq_o carries the request byte. In the cycle after write enable rises, the driver is still on and chip select is still low. In the cycle after that, both are released.
- R6: Output enable and write enable are never low together. mem_dq_oe_o is never high while output enable is low.
- R7: mem_addr_o equals the accepted request address and stays constant for as long as chip select is low.
- R8: req_ready_o is low in every cycle in which chip select is low. A request is taken only in a cycle where req_valid_i and req_ready_o are both high.
- R9: req_ready_o is high in the response cycle of a read and in the cycle after a write releases the bus. A pending request therefore starts its bus cycle on the next clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Controller idle, request taken when valid |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 15 | Byte address |
| req_wdata_i | input | 8 | Write byte |
| rsp_valid_o | output | 1 | One-cycle pulse with read data |
| rsp_rdata_o | output | 8 | Read byte |
| mem_addr_o | output | 15 | RAM address |
| mem_ce_no | output | 1 | RAM chip select, active low |
| mem_oe_no | output | 1 | RAM output enable, active low |
| mem_we_no | output | 1 | RAM write enable, active low |
| mem_dq_o | output | 8 | Byte driven toward the RAM |
| mem_dq_i | input | 8 | Byte seen on the RAM data bus |
| mem_dq_oe_o | output | 1 | Enables the controller's data drivers |

## Verification
The bench builds the controller with RD_CYC = 3, TURN_CYC = 2, SETUP_CYC = 2 and WE_MIN_CYC = 6. With these values the strobe-width floor, not the turnaround-plus-setup sum, sets the write pulse. The gap between the driver turn-on and the write end is also longer than the setup minimum, so a driver that starts early or late shows up as a count mismatch. Its RAM model presents valid data only in the last cycle of the read window, which exposes any capture taken too early. Write commits are taken from mem_dq_o at the rising write strobe, so a driver released too early is caught as well.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_READ,
    PH_WRITE,
    PH_HOLD
  } phase_e;

  function automatic int unsigned max_u(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctrl_timer.sv
module sram_ctrl_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  output logic [CNT_W-1:0] cnt_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_o <= '0;
    else if (clear_i) cnt_o <= '0;
    else              cnt_o <= cnt_o + 1'b1;
  end

endmodule

// File: rtl/sram_ctrl_seq.sv
module sram_ctrl_seq
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned RD_CYC   = 6,
  parameter int unsigned TURN_CYC = 2,
  parameter int unsigned WE_CYC   = 5,
  parameter int unsigned CNT_W    = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_valid_i,
  input  logic req_we_i,
  output logic req_ready_o,
  output logic accept_o,
  output logic capture_o,
  output logic rsp_valid_o,
  output logic ce_no,
  output logic oe_no,
  output logic we_no,
  output logic dq_oe_o
);

  localparam logic [CNT_W-1:0] RdLast = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] WeLast = CNT_W'(WE_CYC - 1);

  phase_e           phase_q;
  logic [CNT_W-1:0] cnt;
  logic             drive_at_start;
  logic             drive_mid;

  sram_ctrl_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(phase_q == PH_IDLE),
    .cnt_o  (cnt)
  );

  // driver turn-on point after the RAM has released the bus
  generate
    if (TURN_CYC == 0) begin : g_drv_now
      assign drive_at_start = 1'b1;
      assign drive_mid      = 1'b0;
    end else begin : g_drv_late
      assign drive_at_start = 1'b0;
      assign drive_mid      = (cnt == CNT_W'(TURN_CYC - 1));
    end
  endgenerate

  assign req_ready_o = (phase_q == PH_IDLE);
  assign accept_o    = req_ready_o && req_valid_i;
  assign capture_o   = (phase_q == PH_READ) && (cnt == RdLast);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q     <= PH_IDLE;
      ce_no       <= 1'b1;
      oe_no       <= 1'b1;
      we_no       <= 1'b1;
      dq_oe_o     <= 1'b0;
      rsp_valid_o <= 1'b0;
    end else begin
      rsp_valid_o <= 1'b0;
      unique case (phase_q)
        PH_IDLE: begin
          if (req_valid_i) begin
            ce_no <= 1'b0;
            if (req_we_i) begin
              we_no   <= 1'b0;
              dq_oe_o <= drive_at_start;
              phase_q <= PH_WRITE;
            end else begin
              oe_no   <= 1'b0;
              phase_q <= PH_READ;
            end
          end
        end
        PH_READ: begin
          if (cnt == RdLast) begin
            ce_no       <= 1'b1;
            oe_no       <= 1'b1;
            rsp_valid_o <= 1'b1;
            phase_q     <= PH_IDLE;
          end
        end
        PH_WRITE: begin
          if (drive_mid) dq_oe_o <= 1'b1;
          if (cnt == WeLast) begin
            we_no   <= 1'b1;
            phase_q <= PH_HOLD;
          end
        end
        PH_HOLD: begin
          ce_no   <= 1'b1;
          dq_oe_o <= 1'b0;
          phase_q <= PH_IDLE;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sram_ctrl_datapath.sv
module sram_ctrl_datapath #(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic              capture_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic [DATA_W-1:0] rsp_rdata_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_addr_o <= '0;
      mem_dq_o   <= '0;
    end else if (accept_i) begin
      mem_addr_o <= req_addr_i;
      mem_dq_o   <= req_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        rsp_rdata_o <= '0;
    else if (capture_i) rsp_rdata_o <= mem_dq_i;
  end

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W     = 15,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned RD_CYC     = 6,
  parameter int unsigned TURN_CYC   = 2,
  parameter int unsigned SETUP_CYC  = 3,
  parameter int unsigned WE_MIN_CYC = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_ce_no,
  output logic              mem_oe_no,
  output logic              mem_we_no,
  output logic [DATA_W-1:0] mem_dq_o,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic              mem_dq_oe_o
);

  localparam int unsigned WE_CYC = max_u(TURN_CYC + SETUP_CYC, WE_MIN_CYC);
  localparam int unsigned CNT_W  = $clog2(max_u(RD_CYC, WE_CYC) + 1);

  logic accept;
  logic capture;

  sram_ctrl_seq #(
    .RD_CYC  (RD_CYC),
    .TURN_CYC(TURN_CYC),
    .WE_CYC  (WE_CYC),
    .CNT_W   (CNT_W)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_valid_i(req_valid_i),
    .req_we_i   (req_we_i),
    .req_ready_o(req_ready_o),
    .accept_o   (accept),
    .capture_o  (capture),
    .rsp_valid_o(rsp_valid_o),
    .ce_no      (mem_ce_no),
    .oe_no      (mem_oe_no),
    .we_no      (mem_we_no),
    .dq_oe_o    (mem_dq_oe_o)
  );

  sram_ctrl_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_dp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .accept_i   (accept),
    .capture_i  (capture),
    .req_addr_i (req_addr_i),
    .req_wdata_i(req_wdata_i),
    .mem_dq_i   (mem_dq_i),
    .mem_addr_o (mem_addr_o),
    .mem_dq_o   (mem_dq_o),
    .rsp_rdata_o(rsp_rdata_o)
  );

endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned WE_CYC = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_ready_o,
  input logic              rsp_valid_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_ce_no,
  input logic              mem_oe_no,
  input logic              mem_we_no,
  input logic              mem_dq_oe_o
);

  logic [15:0] we_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         we_run <= '0;
    else if (!mem_we_no) we_run <= we_run + 16'd1;
    else                 we_run <= '0;
  end

  // R4
  we_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_no) |-> we_run == 16'(WE_CYC));

  // R4
  we_needs_ce_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_no |-> !mem_ce_no);

  // R5
  data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_no) |-> (mem_dq_oe_o && !mem_ce_no));

  // R6
  oe_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_we_no) |-> (mem_oe_no && $past(mem_oe_no)));

  // R6
  no_contention_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_dq_oe_o |-> mem_oe_no);

  // R7
  addr_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_ce_no && $past(!mem_ce_no)) |-> $stable(mem_addr_o));

  // R3
  rsp_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  // R8
  busy_not_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_ce_no |-> !req_ready_o);

endmodule

bind sram_ctrl sram_ctrl_chk #(
  .ADDR_W(ADDR_W),
  .WE_CYC(WE_CYC)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_ready_o(req_ready_o),
  .rsp_valid_o(rsp_valid_o),
  .mem_addr_o (mem_addr_o),
  .mem_ce_no  (mem_ce_no),
  .mem_oe_no  (mem_oe_no),
  .mem_we_no  (mem_we_no),
  .mem_dq_oe_o(mem_dq_oe_o)
);

// File: tb/sram_ctrl_test.sv
module sram_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int RD     = 3;
  localparam int TURN   = 2;
  localparam int SETUP  = 2;
  localparam int WE_MIN = 6;
  localparam int WE_EXP = (TURN + SETUP > WE_MIN) ? TURN + SETUP : WE_MIN;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_we = 1'b0;
  logic [14:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [7:0]  rsp_rdata;
  logic [14:0] mem_addr;
  logic        mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [7:0]  mem_dq_o, mem_dq_i;

  int checks = 0;
  int fails  = 0;

  logic [7:0]  ram    [256];
  logic [7:0]  shadow [256];
  int          oe_age = 0;
  logic [14:0] cur_addr = '0;
  logic [7:0]  exp_w = '0;
  logic [7:0]  exp_r = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_ctrl #(
    .RD_CYC(RD), .TURN_CYC(TURN), .SETUP_CYC(SETUP), .WE_MIN_CYC(WE_MIN)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_we_i(req_we),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .mem_addr_o(mem_addr), .mem_ce_no(mem_ce_n), .mem_oe_no(mem_oe_n),
    .mem_we_no(mem_we_n), .mem_dq_o(mem_dq_o), .mem_dq_i(mem_dq_i),
    .mem_dq_oe_o(mem_dq_oe)
  );

  // RAM model: data valid only in the last cycle of the read window
  always @(posedge clk) oe_age <= mem_oe_n ? 0 : oe_age + 1;
  assign mem_dq_i = (!mem_ce_n && !mem_oe_n && mem_we_n && oe_age >= RD - 1)
                    ? ram[mem_addr[7:0]] : 8'hEE;

  function automatic logic [7:0] seed_byte(int i);
    return 8'((i * 37 + 5) & 255);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // bus monitor
  int we_lo = 0, oe_lo = 0;
  bit prev_we = 1'b1, prev_oe = 1'b1, drive_seen = 1'b0, hold_next = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!mem_ce_n) begin
        check(mem_addr == cur_addr, "R7", "address", int'(mem_addr), int'(cur_addr));
        check(!req_ready, "R8", "ready while busy", int'(req_ready), 0);
      end
      if (!mem_we_n) check(mem_oe_n, "R6", "oe during write", int'(mem_oe_n), 1);
      if (mem_dq_oe) check(mem_oe_n, "R6", "drive with oe low", int'(mem_oe_n), 1);

      if (!mem_we_n) begin
        we_lo++;
        if (mem_dq_oe && !drive_seen) begin
          drive_seen = 1'b1;
          check(we_lo == TURN + 1, "R5", "driver turn-on", we_lo, TURN + 1);
        end
      end else if (!prev_we) begin
        check(we_lo == WE_EXP, "R4", "we width", we_lo, WE_EXP);
        check(mem_dq_oe && !mem_ce_n, "R5", "hold after we rise",
              int'({mem_dq_oe, mem_ce_n}), 2);
        check(mem_dq_o == exp_w, "R5", "write data", int'(mem_dq_o), int'(exp_w));
        ram[mem_addr[7:0]] = mem_dq_o;
        we_lo = 0;
        drive_seen = 1'b0;
        hold_next = 1'b1;
      end else if (hold_next) begin
        check(!mem_dq_oe && mem_ce_n, "R5", "release", int'({mem_dq_oe, mem_ce_n}), 1);
        check(req_ready, "R9", "ready after write", int'(req_ready), 1);
        hold_next = 1'b0;
      end

      if (!mem_oe_n) begin
        oe_lo++;
        check(mem_we_n && !mem_ce_n, "R2", "read strobes",
              int'({mem_we_n, mem_ce_n}), 2);
      end else if (!prev_oe) begin
        check(oe_lo == RD, "R2", "read width", oe_lo, RD);
        check(rsp_valid, "R3", "rsp_valid", int'(rsp_valid), 1);
        check(rsp_rdata == exp_r, "R3", "read data", int'(rsp_rdata), int'(exp_r));
        check(req_ready, "R9", "ready in rsp cycle", int'(req_ready), 1);
        oe_lo = 0;
      end else begin
        check(!rsp_valid, "R3", "stray rsp_valid", int'(rsp_valid), 0);
      end
      prev_we = mem_we_n;
      prev_oe = mem_oe_n;
    end
  end

  // caller is at a negedge; returns at the negedge after acceptance
  task automatic issue(input bit we, input logic [14:0] a, input logic [7:0] d);
    req_we    = we;
    req_addr  = a;
    req_wdata = d;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    cur_addr = a;
    exp_w    = d;
    exp_r    = shadow[a[7:0]];
    if (we) shadow[a[7:0]] = d;
    @(negedge clk);
    req_valid = 1'b0;
    // R8: taken on that edge, so the bus is now busy
    check(!req_ready && !mem_ce_n, "R8", "accept", int'({req_ready, mem_ce_n}), 0);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    logic [31:0] r;
    for (int i = 0; i < 256; i++) begin
      ram[i]    = seed_byte(i);
      shadow[i] = seed_byte(i);
    end
    r = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    // R1
    check(mem_ce_n && mem_oe_n && mem_we_n, "R1", "strobes in reset",
          int'({mem_ce_n, mem_oe_n, mem_we_n}), 7);
    check(!mem_dq_oe && !rsp_valid && req_ready, "R1", "idle in reset",
          int'({mem_dq_oe, rsp_valid, req_ready}), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe, "R1", "after reset",
          int'({mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe}), 14);

    // directed corners
    issue(1'b0, 15'h0000, 8'h00);
    issue(1'b0, 15'h7FFF, 8'h00);
    issue(1'b1, 15'h7FFF, 8'hFF);
    issue(1'b0, 15'h7FFF, 8'h00);
    issue(1'b1, 15'h0000, 8'h00);
    issue(1'b1, 15'h0001, 8'hA5);
    issue(1'b0, 15'h0000, 8'h00);
    issue(1'b0, 15'h0001, 8'h00);
    issue(1'b0, 15'h0001, 8'h00);
    issue(1'b1, 15'h2A55, 8'h3C);
    issue(1'b0, 15'h2A55, 8'h00);
    repeat (4) @(negedge clk);

    for (int i = 0; i < 250; i++) begin
      r = $urandom;
      issue(r[0], r[15:1], r[23:16]);
      if (r[31:30] == 2'b00) repeat (int'(r[29:27])) @(negedge clk);
    end

    repeat (WE_EXP + RD + 6) @(negedge clk);
    summary();
  end

endmodule